// File: doc/BRIEF.md
# I2C Target Address Matcher with Keyed Software Reset

This block sits behind a bit-level I2C front end and judges the first byte after every START. It compares the 7-bit address in that byte against the device's own address, the top three bits of which are fixed at `100` and the low four taken from strap pins. It also compares against a programmable broadcast address and three programmable group addresses, each gated by its own enable. When any of these hit, the block acknowledges the byte. It raises an `addressed` flag and records the read/write bit, and it acknowledges the write data bytes that follow until STOP or a repeated START.

One 7-bit address, `1001011`, is reserved for a bus-wide reset request. After that address arrives in write form, the block expects a two-byte key, `A5h` then `5Ah`. If STOP follows both key bytes correctly, it emits a single-cycle `soft_rst` pulse that the surrounding logic uses to return every register to its power-up value. Any refused byte aborts the sequence, and the block then stays silent until the next START. Several simultaneous matches are treated the same way, because they all lead to the same register set.

Top module: `i2c_addr_match`

## Requirements
- R1: An address byte equal to `{3'b100, strap[3:0], rw}` is acknowledged. `dec_vld` and `dec_ack` are high in the cycle after `byte_vld`, and from that cycle on `addressed` is 1 and `rnw` equals bit 0 of the byte.
- R2: The broadcast address (`allcall_addr`, 7-bit) is acknowledged for both rw values when `allcall_en` is 1, and refused (`dec_vld`=1, `dec_ack`=0) when it is 0.
- R3: Group address k, held in `sub_addr[7k+6:7k]`, is acknowledged for both rw values only while `sub_en[k]` is 1.
- R4: An address byte that matches nothing is refused. `addressed` stays 0, and later bytes produce no decision (`dec_vld` stays 0) until the next START.
- R5: The reserved address `1001011` is acknowledged in write form (byte `96h`) and refused in read form (byte `97h`).
- R6: After an acknowledged `96h`, the first data byte is acknowledged only if it is `A5h` and the second only if it is `5Ah`. A wrong value is refused and aborts the sequence, so no reset follows at STOP.
- R7: Any byte after the two key bytes is refused and aborts the sequence.
- R8: `soft_rst` is a one-cycle pulse in the cycle after STOP, issued only when both key bytes were acknowledged with no intervening START.
- R9: START, repeated or not, clears `addressed` in the following cycle and re-evaluates the next byte as an address. STOP clears `addressed` as well.
- R10: While addressed in write mode, every data byte is acknowledged. In read mode, data bytes produce no decision.
- R11: The reserved address takes precedence over every other match, including a strapped or programmed address equal to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_evt | input | 1 | One-cycle START or repeated START event |
| stop_evt | input | 1 | One-cycle STOP event |
| byte_vld | input | 1 | One-cycle strobe: a full byte was received |
| byte_val | input | 8 | Received byte, MSB first on the bus |
| strap | input | 4 | Low four bits of the device address |
| allcall_addr | input | 7 | Programmable broadcast address |
| allcall_en | input | 1 | Broadcast address enable |
| sub_addr | input | 21 | Three packed 7-bit group addresses |
| sub_en | input | 3 | Per-group address enable |
| dec_vld | output | 1 | A decision for the previous byte is valid |
| dec_ack | output | 1 | 1 = acknowledge, 0 = refuse |
| addressed | output | 1 | Device is the selected target |
| rnw | output | 1 | Transfer direction of the current selection, 1 = read |
| soft_rst | output | 1 | One-cycle register reset request |

## Verification
The assertions assume the front end never raises two of `start_evt`, `stop_evt` and `byte_vld` in the same cycle, and that each event lasts exactly one cycle. They also assume that the programmable addresses and enables stay steady during a byte. The stimulus drives each event for one cycle at a falling edge, with idle cycles in between, and changes configuration only between transfers. It covers refused, aborted and accepted key sequences, repeated STARTs mid-sequence, and address collisions with the reserved address.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DEV,
        ST_KEY1,
        ST_KEY2,
        ST_ARMED,
        ST_IGNORE
    } am_state_e;

    typedef struct packed {
        am_state_e state;
        logic      dec_vld;
        logic      dec_ack;
        logic      addressed;
        logic      rnw;
        logic      soft_rst;
    } am_regs_t;

endpackage

// File: rtl/i2c_am_decode.sv
module i2c_am_decode #(
    parameter int ADDR_W            = 7,
    parameter int STRAP_W           = 4,
    parameter int NUM_SUB           = 3,
    parameter logic [ADDR_W-STRAP_W-1:0] DEV_PREFIX = 3'b100,
    parameter logic [ADDR_W-1:0]    RST_ADDR = 7'h4B
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [STRAP_W-1:0]        strap,
    input  logic [ADDR_W-1:0]         allcall_addr,
    input  logic                      allcall_en,
    input  logic [NUM_SUB*ADDR_W-1:0] sub_addr,
    input  logic [NUM_SUB-1:0]        sub_en,
    output logic                      is_rst,
    output logic                      hit
);
    localparam int PFX_W = ADDR_W - STRAP_W;

    logic [NUM_SUB-1:0] sub_hit;
    logic               dev_hit;
    logic               all_hit;

    for (genvar k = 0; k < NUM_SUB; k++) begin : g_sub
        assign sub_hit[k] = sub_en[k] && (addr == sub_addr[k*ADDR_W +: ADDR_W]);
    end

    always_comb begin
        dev_hit = (addr[ADDR_W-1 -: PFX_W] == DEV_PREFIX) &&
                  (addr[STRAP_W-1:0] == strap);
        all_hit = allcall_en && (addr == allcall_addr);
        is_rst  = (addr == RST_ADDR);
        hit     = dev_hit || all_hit || (|sub_hit);
    end

endmodule

// File: rtl/i2c_am_ctrl.sv
module i2c_am_ctrl
    import i2c_am_pkg::*;
#(
    parameter int          BYTE_W = 8,
    parameter logic [BYTE_W-1:0] KEY_A = 8'hA5,
    parameter logic [BYTE_W-1:0] KEY_B = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic              is_rst,
    input  logic              hit,
    output logic              dec_vld,
    output logic              dec_ack,
    output logic              addressed,
    output logic              rnw,
    output logic              soft_rst
);
    localparam am_regs_t REGS_RST = '{
        state: ST_IDLE, dec_vld: 1'b0, dec_ack: 1'b0,
        addressed: 1'b0, rnw: 1'b0, soft_rst: 1'b0};

    am_regs_t r_d, r_q;

    always_comb begin
        r_d          = r_q;
        r_d.dec_vld  = 1'b0;
        r_d.dec_ack  = 1'b0;
        r_d.soft_rst = 1'b0;
        if (start_evt) begin
            r_d.state     = ST_ADDR;
            r_d.addressed = 1'b0;
            r_d.rnw       = 1'b0;
        end else if (stop_evt) begin
            r_d.soft_rst  = (r_q.state == ST_ARMED);
            r_d.state     = ST_IDLE;
            r_d.addressed = 1'b0;
            r_d.rnw       = 1'b0;
        end else if (byte_vld) begin
            unique case (r_q.state)
                ST_ADDR: begin
                    r_d.dec_vld = 1'b1;
                    if (is_rst) begin
                        r_d.dec_ack = !byte_val[0];
                        r_d.state   = byte_val[0] ? ST_IGNORE : ST_KEY1;
                    end else if (hit) begin
                        r_d.dec_ack   = 1'b1;
                        r_d.addressed = 1'b1;
                        r_d.rnw       = byte_val[0];
                        r_d.state     = ST_DEV;
                    end else begin
                        r_d.state = ST_IGNORE;
                    end
                end
                ST_DEV: begin
                    if (!r_q.rnw) begin
                        r_d.dec_vld = 1'b1;
                        r_d.dec_ack = 1'b1;
                    end
                end
                ST_KEY1: begin
                    r_d.dec_vld = 1'b1;
                    r_d.dec_ack = (byte_val == KEY_A);
                    r_d.state   = (byte_val == KEY_A) ? ST_KEY2 : ST_IGNORE;
                end
                ST_KEY2: begin
                    r_d.dec_vld = 1'b1;
                    r_d.dec_ack = (byte_val == KEY_B);
                    r_d.state   = (byte_val == KEY_B) ? ST_ARMED : ST_IGNORE;
                end
                ST_ARMED: begin
                    r_d.dec_vld = 1'b1;
                    r_d.state   = ST_IGNORE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign dec_vld   = r_q.dec_vld;
    assign dec_ack   = r_q.dec_ack;
    assign addressed = r_q.addressed;
    assign rnw       = r_q.rnw;
    assign soft_rst  = r_q.soft_rst;

    // R1: a decision only ever answers a byte strobe of the previous cycle
    assert_dec_follows_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |-> $past(byte_vld));

    // R8: reset request lasts one cycle and is always caused by STOP
    assert_rst_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !soft_rst);
    assert_rst_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> $past(stop_evt));

    // R9: any START deselects the device
    assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_evt) |-> !addressed);

    // R5: a read-form reserved address is never acknowledged
    assert_rst_read_nack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && $past(r_q.state == ST_ADDR) && $past(is_rst) && $past(byte_val[0]))
        |-> !dec_ack);

    // R4: once refused, the bus is ignored until START
    assert_ignore_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(r_q.state == ST_IGNORE) && !$past(start_evt)) |-> !dec_vld);

    // R10: a read selection never produces decisions for data bytes
    assert_read_no_dec_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(r_q.state == ST_DEV) && $past(rnw)) |-> !dec_vld);

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
    parameter int ADDR_W  = 7,
    parameter int STRAP_W = 4,
    parameter int NUM_SUB = 3,
    parameter logic [ADDR_W-1:0] RST_ADDR = 7'h4B
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_evt,
    input  logic                      stop_evt,
    input  logic                      byte_vld,
    input  logic [ADDR_W:0]           byte_val,
    input  logic [STRAP_W-1:0]        strap,
    input  logic [ADDR_W-1:0]         allcall_addr,
    input  logic                      allcall_en,
    input  logic [NUM_SUB*ADDR_W-1:0] sub_addr,
    input  logic [NUM_SUB-1:0]        sub_en,
    output logic                      dec_vld,
    output logic                      dec_ack,
    output logic                      addressed,
    output logic                      rnw,
    output logic                      soft_rst
);
    localparam int BYTE_W = ADDR_W + 1;

    logic is_rst;
    logic hit;

    i2c_am_decode #(
        .ADDR_W   (ADDR_W),
        .STRAP_W  (STRAP_W),
        .NUM_SUB  (NUM_SUB),
        .RST_ADDR (RST_ADDR)
    ) u_decode (
        .addr         (byte_val[ADDR_W:1]),
        .strap        (strap),
        .allcall_addr (allcall_addr),
        .allcall_en   (allcall_en),
        .sub_addr     (sub_addr),
        .sub_en       (sub_en),
        .is_rst       (is_rst),
        .hit          (hit)
    );

    i2c_am_ctrl #(
        .BYTE_W (BYTE_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .byte_vld  (byte_vld),
        .byte_val  (byte_val),
        .is_rst    (is_rst),
        .hit       (hit),
        .dec_vld   (dec_vld),
        .dec_ack   (dec_ack),
        .addressed (addressed),
        .rnw       (rnw),
        .soft_rst  (soft_rst)
    );

endmodule

// File: tb/tb_i2c_addr_match.sv
`timescale 1ns/1ps
module tb_i2c_addr_match;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_evt = 1'b0, stop_evt = 1'b0, byte_vld = 1'b0;
    logic [7:0]  byte_val = 8'h00;
    logic [3:0]  strap = 4'b0110;
    logic [6:0]  allcall_addr = 7'h48;
    logic        allcall_en = 1'b1;
    logic [20:0] sub_addr = {7'h4C, 7'h4A, 7'h49};
    logic [2:0]  sub_en = 3'b000;
    logic        dec_vld, dec_ack, addressed, rnw, soft_rst;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit    exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    i2c_addr_match dut (
        .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
        .byte_vld(byte_vld), .byte_val(byte_val), .strap(strap),
        .allcall_addr(allcall_addr), .allcall_en(allcall_en),
        .sub_addr(sub_addr), .sub_en(sub_en), .dec_vld(dec_vld),
        .dec_ack(dec_ack), .addressed(addressed), .rnw(rnw), .soft_rst(soft_rst));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every decision
    always @(negedge clk) begin
        if (rst_n && dec_vld) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected decision", 1, 0);
            end else begin
                automatic bit    e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(dec_ack == e, t, dec_ack, e);
            end
        end
    end

    task automatic do_start();
        @(negedge clk) start_evt = 1'b1;
        @(negedge clk) start_evt = 1'b0;
        chk(addressed == 1'b0, "R9 addressed after START", addressed, 0);
    endtask

    task automatic send(input logic [7:0] v, input bit has_dec, input bit ack, input string tag);
        if (has_dec) begin
            exp_q.push_back(ack);
            tag_q.push_back(tag);
        end
        @(negedge clk) begin byte_vld = 1'b1; byte_val = v; end
        @(negedge clk) byte_vld = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_stop(input bit exp_rst, input string tag);
        @(negedge clk) stop_evt = 1'b1;
        @(negedge clk) stop_evt = 1'b0;
        chk(soft_rst == exp_rst, tag, soft_rst, exp_rst);
        chk(addressed == 1'b0, "R9 addressed after STOP", addressed, 0);
        @(negedge clk);
        chk(soft_rst == 1'b0, "R8 pulse width", soft_rst, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dec_vld == 0 && addressed == 0 && soft_rst == 0, "R1 reset state",
            {dec_vld, addressed, soft_rst}, 0);

        // own address, write then data
        do_start();
        send(8'h8C, 1, 1, "R1 own write");
        chk(addressed == 1 && rnw == 0, "R1 addressed/rnw", {addressed, rnw}, 2);
        send(8'h12, 1, 1, "R10 write data");
        send(8'h34, 1, 1, "R10 write data 2");
        do_stop(0, "R8 no reset on plain write");

        // own address, read; data bytes silent
        do_start();
        send(8'h8D, 1, 1, "R1 own read");
        chk(rnw == 1, "R1 rnw read", rnw, 1);
        send(8'hEE, 0, 0, "R10 read data");
        do_stop(0, "R8 no reset on read");

        // broadcast, both forms, with repeated START
        do_start();
        send(8'h90, 1, 1, "R2 allcall write");
        do_start();
        send(8'h91, 1, 1, "R2 allcall read");
        chk(rnw == 1, "R9 rnw after restart", rnw, 1);
        do_stop(0, "R8 none");
        allcall_en = 1'b0;
        do_start();
        send(8'h90, 1, 0, "R2 allcall disabled");
        do_stop(0, "R8 none");
        allcall_en = 1'b1;

        // group addresses
        do_start();
        send(8'h92, 1, 0, "R3 sub disabled");
        send(8'h55, 0, 0, "R4 ignored after nack");
        chk(addressed == 0, "R4 not addressed", addressed, 0);
        do_stop(0, "R8 none");
        sub_en = 3'b010;
        do_start();
        send(8'h94, 1, 1, "R3 sub1 write");
        do_start();
        send(8'h95, 1, 1, "R3 sub1 read");
        do_start();
        send(8'h92, 1, 0, "R3 sub0 still disabled");
        do_start();
        send(8'h98, 1, 0, "R3 sub2 still disabled");
        do_stop(0, "R8 none");
        sub_en = 3'b000;

        // foreign address
        do_start();
        send(8'h20, 1, 0, "R4 no match");
        send(8'h20, 0, 0, "R4 silent");
        do_stop(0, "R8 none");

        // good reset sequence
        do_start();
        send(8'h96, 1, 1, "R5 reset call write");
        send(8'hA5, 1, 1, "R6 key A");
        send(8'h5A, 1, 1, "R6 key B");
        do_stop(1, "R8 reset pulse");

        // read form refused
        do_start();
        send(8'h97, 1, 0, "R5 reset call read");
        send(8'hA5, 0, 0, "R4 silent after nack");
        do_stop(0, "R5 no reset after read form");

        // bad keys
        do_start();
        send(8'h96, 1, 1, "R5 reset call");
        send(8'hA5, 1, 1, "R6 key A");
        send(8'h00, 1, 0, "R6 bad key B");
        do_stop(0, "R6 no reset after bad key");
        do_start();
        send(8'h96, 1, 1, "R5 reset call");
        send(8'h5A, 1, 0, "R6 bad key A");
        send(8'h5A, 0, 0, "R6 silent after abort");
        do_stop(0, "R6 no reset");

        // extra byte
        do_start();
        send(8'h96, 1, 1, "R5 reset call");
        send(8'hA5, 1, 1, "R6 key A");
        send(8'h5A, 1, 1, "R6 key B");
        send(8'hFF, 1, 0, "R7 third byte");
        do_stop(0, "R7 no reset after extra byte");

        // restart mid sequence
        do_start();
        send(8'h96, 1, 1, "R5 reset call");
        send(8'hA5, 1, 1, "R6 key A");
        do_start();
        send(8'h8C, 1, 1, "R9 re-evaluated address");
        do_stop(0, "R9 no reset after restart");

        // precedence over a group address equal to the reserved one
        sub_addr[6:0] = 7'h4B;
        sub_en = 3'b001;
        do_start();
        send(8'h97, 1, 0, "R11 reserved read beats sub");
        do_stop(0, "R8 none");
        do_start();
        send(8'h96, 1, 1, "R11 reserved write");
        chk(addressed == 0, "R11 not addressed by sub", addressed, 0);
        send(8'hA5, 1, 1, "R11 key A");
        send(8'h5A, 1, 1, "R11 key B");
        do_stop(1, "R11 reset pulse");
        sub_en = 3'b000;

        // precedence over strapped address
        strap = 4'b1011;
        do_start();
        send(8'h97, 1, 0, "R11 reserved read beats strap");
        do_stop(0, "R8 none");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R1 all decisions seen", exp_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule